// File: doc/BRIEF.md
# UART Interrupt Identifier

This block sits beside a UART channel and turns five interrupt conditions into a single identification code and one interrupt line. The conditions are receiver line status, received data ready, receive data time-out, transmitter holding register empty, and modem status. Each has its own enable bit. Of the enabled conditions that are pending, only the one with the highest priority is reported, as a 4-bit code that the host reads from its status register. A lower-priority condition appears only after every higher one has been serviced by its owning logic and the code is read again.

Four of the conditions are level flags. Their owning logic clears them, for example through a line status read or a data read. The transmitter-empty condition is different: it is an event. It is latched here when the holding register becomes empty. It is cleared when the host reads the code while the code shows it, or when the host writes new transmit data. The block has no data stream, so all of its pins are plain control and status signals with no handshake.

The code and the interrupt line are registered. They reflect the inputs sampled at the previous rising clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and right after it, `int_id` is 4'b0001 and `irq` is low.
- R2: If the receiver line status flag is pending and enabled (`irq_en[0]`), the next cycle shows code 4'b0110, whatever the other sources are doing.
- R3: If a receive time-out is pending and enabled (`irq_en[1]`) and no enabled line status is pending, the next cycle shows code 4'b1100. This holds even when data ready is also pending.
- R4: If data ready is pending and enabled (`irq_en[2]`) and neither of the two higher sources is enabled and pending, the next cycle shows code 4'b0100.
- R5: A rising edge of `thr_empty` (including its first high level after reset) sets a latched transmitter-empty pending state. While that state is set and enabled (`irq_en[3]`) and no level-1 or level-2 source is enabled and pending, the code is 4'b0010.
- R6: Modem status, when enabled (`irq_en[4]`), has the lowest priority. It shows code 4'b0000 only when no other enabled source is pending.
- R7: When no enabled source is pending, the code is 4'b0001. `irq` is high exactly when bit 0 of the code is 0.
- R8: A source whose enable bit is clear has no effect on `int_id` or `irq`.
- R9: A status read (`stat_rd`) clears the transmitter-empty pending state only if `int_id` shows 4'b0010 in the cycle of the read. A read in any other cycle leaves that state unchanged.
- R10: A `tx_wr` pulse clears the transmitter-empty pending state. A rising edge of `thr_empty` in the same cycle as a clearing read or write leaves the state set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 5 | Enables: [0] line status, [1] time-out, [2] data ready, [3] transmitter empty, [4] modem |
| lsr_flag | input | 1 | Receiver line status condition |
| rx_ready | input | 1 | Received data ready condition |
| rx_timeout | input | 1 | Receive data time-out condition |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| msr_flag | input | 1 | Modem status change condition |
| tx_wr | input | 1 | Host writes transmit data (one-cycle pulse) |
| stat_rd | input | 1 | Host reads the status code (one-cycle pulse) |
| int_id | output | 4 | Highest pending interrupt code |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two things can happen in the same cycle. A status read can clear the latched transmitter-empty state, while a new rising edge of `thr_empty` sets it again. A `tx_wr` clear can also meet such an edge. The bench provokes both coincidences directly. Its random phase toggles `thr_empty`, `stat_rd` and `tx_wr` independently, so they also collide there. In every case a bench-side model applies "set wins over clear" and predicts the code two cycles on. A read that arrives while a higher code is shown must leave the state pending, and the bench checks this once the higher source drops.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W  = 4;
  localparam int N_SRC = 5;

  // source index doubles as priority rank: 0 is served first
  localparam int SRC_LS   = 0;
  localparam int SRC_TMO  = 1;
  localparam int SRC_RDY  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MS   = 4;

  localparam logic [ID_W-1:0] ID_LS   = 4'b0110;
  localparam logic [ID_W-1:0] ID_TMO  = 4'b1100;
  localparam logic [ID_W-1:0] ID_RDY  = 4'b0100;
  localparam logic [ID_W-1:0] ID_THRE = 4'b0010;
  localparam logic [ID_W-1:0] ID_MS   = 4'b0000;
  localparam logic [ID_W-1:0] ID_NONE = 4'b0001;

  function automatic logic [ID_W-1:0] src_code(input int idx);
    case (idx)
      SRC_LS:   return ID_LS;
      SRC_TMO:  return ID_TMO;
      SRC_RDY:  return ID_RDY;
      SRC_THRE: return ID_THRE;
      default:  return ID_MS;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_thre_latch.sv
module uart_irq_thre_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic tx_wr,
  input  logic rd_clr,
  output logic pend
);
  logic te_q;
  logic te_rise;

  assign te_rise = thr_empty && !te_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q <= 1'b0;
      pend <= 1'b0;
    end else begin
      te_q <= thr_empty;
      if (te_rise)
        pend <= 1'b1;
      else if (tx_wr || rd_clr)
        pend <= 1'b0;
    end
  end

  AST_THRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    te_rise |=> pend); // R5
  AST_THRE_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !te_rise) |=> !pend); // R10
  AST_THRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_wr && !rd_clr && !te_rise) |=> $stable(pend)); // R9
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int IW = ID_W
) (
  input  logic [NS-1:0] req,
  output logic [IW-1:0] id,
  output logic          any
);
  always_comb begin
    id = ID_NONE;
    // walk from lowest rank upward so the highest-priority request wins
    for (int i = NS - 1; i >= 0; i--) begin
      if (req[i]) id = src_code(i);
    end
  end

  assign any = |req;

  always_comb begin
    if (any) assert (id[0] == 1'b0); // R7
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             lsr_flag,
  input  logic             rx_ready,
  input  logic             rx_timeout,
  input  logic             thr_empty,
  input  logic             msr_flag,
  input  logic             tx_wr,
  input  logic             stat_rd,
  output logic [ID_W-1:0]  int_id,
  output logic             irq
);
  logic [N_SRC-1:0] raw;
  logic [N_SRC-1:0] masked;
  logic             thre_pend;
  logic             rd_clr;
  logic [ID_W-1:0]  id_nxt;
  logic             any_nxt;

  assign raw[SRC_LS]   = lsr_flag;
  assign raw[SRC_TMO]  = rx_timeout;
  assign raw[SRC_RDY]  = rx_ready;
  assign raw[SRC_THRE] = thre_pend;
  assign raw[SRC_MS]   = msr_flag;

  for (genvar g = 0; g < N_SRC; g++) begin : g_mask
    assign masked[g] = raw[g] & irq_en[g];
  end

  // the read only retires the transmitter event if that is what it saw
  assign rd_clr = stat_rd && (int_id == ID_THRE);

  uart_irq_thre_latch u_thre (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_empty (thr_empty),
    .tx_wr     (tx_wr),
    .rd_clr    (rd_clr),
    .pend      (thre_pend)
  );

  uart_irq_prio_enc #(.NS(N_SRC), .IW(ID_W)) u_enc (
    .req (masked),
    .id  (id_nxt),
    .any (any_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_id <= ID_NONE;
      irq    <= 1'b0;
    end else begin
      int_id <= id_nxt;
      irq    <= any_nxt;
    end
  end

  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (int_id[0] == 1'b0)); // R7
  AST_LS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_flag && irq_en[SRC_LS]) |=> (int_id == ID_LS)); // R2
  AST_TMO_OVER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lsr_flag && irq_en[SRC_LS]) && rx_timeout && irq_en[SRC_TMO])
      |=> (int_id == ID_TMO)); // R3
  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |=> (int_id == ID_NONE && !irq)); // R8
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] irq_en = '0;
  logic       lsr_flag = 0, rx_ready = 0, rx_timeout = 0, thr_empty = 0;
  logic       msr_flag = 0, tx_wr = 0, stat_rd = 0;
  logic [3:0] int_id;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic       m_pend = 1'b0;
  logic       m_te = 1'b0;
  logic [3:0] m_id = 4'b0001;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .lsr_flag(lsr_flag),
    .rx_ready(rx_ready), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
    .msr_flag(msr_flag), .tx_wr(tx_wr), .stat_rd(stat_rd),
    .int_id(int_id), .irq(irq)
  );

  function automatic logic [3:0] ref_code(logic [4:0] en, logic ls, logic tmo,
                                          logic rdy, logic pend, logic ms);
    if (en[0] && ls)   return 4'b0110;
    if (en[1] && tmo)  return 4'b1100;
    if (en[2] && rdy)  return 4'b0100;
    if (en[3] && pend) return 4'b0010;
    if (en[4] && ms)   return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'b0110: return "R2";
      4'b1100: return "R3";
      4'b0100: return "R4";
      4'b0010: return "R5";
      4'b0000: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // drive one cycle, advance model, check result after the edge
  task automatic step(logic [4:0] en, logic ls, logic tmo, logic rdy,
                      logic te, logic ms, logic wr, logic rd, string tag);
    logic [3:0] nxt;
    logic rise;
    irq_en = en; lsr_flag = ls; rx_timeout = tmo; rx_ready = rdy;
    thr_empty = te; msr_flag = ms; tx_wr = wr; stat_rd = rd;
    nxt  = ref_code(en, ls, tmo, rdy, m_pend, ms);
    rise = te && !m_te;
    if (rise) m_pend = 1'b1;
    else if (wr || (rd && m_id == 4'b0010)) m_pend = 1'b0;
    m_te = te;
    m_id = nxt;
    @(negedge clk);
    check((tag == "") ? tag_of(m_id) : tag, int_id, m_id);
    check((tag == "") ? "R7" : tag, {3'b000, irq}, {3'b000, (m_id[0] == 1'b0)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd7741);
    repeat (3) @(negedge clk);
    check("R1", int_id, 4'b0001);
    check("R1", {3'b000, irq}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int_id, 4'b0001);

    // R5: edge of thr_empty latches, shows 0010
    step(5'h1F, 0, 0, 0, 1, 0, 0, 0, "R5");
    step(5'h1F, 0, 0, 0, 1, 0, 0, 0, "R5");
    // R9: read while 0010 shown clears it
    step(5'h1F, 0, 0, 0, 1, 0, 0, 1, "R9");
    step(5'h1F, 0, 0, 0, 1, 0, 0, 0, "R9");
    // R2: line status over everything
    step(5'h1F, 1, 1, 1, 0, 1, 0, 0, "R2");
    // R3: time-out over data ready
    step(5'h1F, 0, 1, 1, 0, 1, 0, 0, "R3");
    step(5'h1F, 0, 0, 1, 0, 1, 0, 0, "R4");
    step(5'h1F, 0, 0, 0, 0, 1, 0, 0, "R6");
    // R8: disabled sources ignored
    step(5'h00, 1, 1, 1, 0, 1, 0, 0, "R8");
    step(5'h1E, 1, 0, 0, 0, 0, 0, 0, "R8");
    step(5'h1F, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R9: read while higher code shown leaves transmitter event pending
    step(5'h1F, 1, 0, 0, 1, 0, 0, 0, "R9");
    step(5'h1F, 1, 0, 0, 1, 0, 0, 1, "R9");
    step(5'h1F, 0, 0, 0, 1, 0, 0, 0, "R9");
    step(5'h1F, 0, 0, 0, 1, 0, 0, 0, "R9");
    // R10: clearing read coincides with new rising edge -> stays set
    step(5'h1F, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(5'h1F, 0, 0, 0, 1, 0, 0, 1, "R10");
    step(5'h1F, 0, 0, 0, 1, 0, 0, 0, "R10");
    // R10: write clears
    step(5'h1F, 0, 0, 0, 1, 0, 1, 0, "R10");
    step(5'h1F, 0, 0, 0, 1, 0, 0, 0, "R10");
    // R10: write coincides with rising edge -> stays set
    step(5'h1F, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(5'h1F, 0, 0, 0, 1, 0, 1, 0, "R10");
    step(5'h1F, 0, 0, 0, 1, 0, 0, 0, "R10");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] en;
      en = (($urandom % 4) == 0) ? 5'($urandom) : 5'h1F;
      step(en, ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0,
           ($urandom % 6) == 0, ($urandom % 3) == 0, "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule